// File: doc/BRIEF.md
# Chainable Command and Status Serial Port

This block is the host-facing serial port of a dual-channel card interface. A host controller talks to it over a three-wire synchronous bus: a serial clock that idles high, a data input and a load strobe. While the strobe is low, each rising serial clock edge shifts one data bit into a 16-bit shift register, most significant bit first. Each falling edge presents the register's top bit on the serial data output. The output is a plain copy of the last register stage, so the output of one device can drive the data input of the next. A host with N devices on one chain shifts 2N bytes and then pulses the strobe once.

The strobe does two jobs. On its rising edge, the word just shifted in is set aside as a pending command, and the parallel status word from the fault logic is loaded into the shift register. The host reads that status back during its next transfer. On the falling edge, the pending command becomes the live command register, which drives the channel logic from the next clock onward. The command register clears to all zeros on reset, so both card channels start unpowered. One command bit, bit 3, turns off the pull-up on the card data line.

All three bus inputs are asynchronous to the block's system clock. They pass through a shared synchronizer, so their relative timing is kept, and the block then acts on edges it detects on the synchronized copies.

Top module: `cmd_status_sport`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), cmd_out is 0x0000, dout is 0 and data_pullup_en is 1.
- R2: While ld is low, each rising sclk edge shifts din into bit 0 of the 16-bit shift register and moves every other bit up by one place. A word therefore enters MSB first over 16 edges.
- R3: cmd_out changes only after a falling ld edge. It then takes the 16 bits that were in the shift register when ld last rose. A rising ld edge on its own leaves cmd_out unchanged.
- R4: A rising ld edge copies status_in into the shift register. Changes to status_in after that edge have no effect on the word read back.
- R5: dout changes only after a falling sclk edge seen while ld is low, and it then shows the shift register's bit 15. In the next transfer, the word read from dout (first bit first) equals the status captured at the previous ld rise.
- R6: sclk edges that occur while ld is high change neither the shift register nor dout.
- R7: When two devices are chained (the first device's dout feeds the second device's din), a 32-bit transfer followed by one ld pulse leaves bits 31..16 in the far device's command register and bits 15..0 in the near device's. The word read from the far device's dout is the far status followed by the near status.
- R8: data_pullup_en is the inverse of command bit 3. It is 0 exactly when the committed command has bit 3 set.
- R9: Between falling ld edges, cmd_out holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles high, asynchronous |
| ld | input | 1 | Load strobe: rising edge captures status, falling edge commits the command |
| din | input | 1 | Serial data in, sampled on rising sclk |
| dout | output | 1 | Serial data out, updated on falling sclk |
| status_in | input | 16 | Parallel status word from the fault and answer-to-reset logic |
| cmd_out | output | 16 | Committed command word to the channel logic |
| data_pullup_en | output | 1 | Card data-line pull-up enable (low when command bit 3 is set) |

## Verification
The embedded properties check several things on every cycle. A strobe rise loads the live status word. A strobe fall moves the pending word into the command register, and the command holds at all other times. The data output moves only after a detected falling clock edge. Strobe-high periods leave the shift register untouched. Other behaviour can only be shown by the bench's scenarios, which look at whole transactions through the ports: MSB-first ordering, reading back one transfer's status during the next, the status being frozen at the strobe rise, and the split of a 32-bit stream across two chained devices. The bench also covers the pull-up control and the reset values.

// File: rtl/sport_pkg.sv
// Package: shared definitions for the chainable command/status serial port.
// Assumes: the events are single-cycle pulses in the system clock domain.
package sport_pkg;

    // Event pulses derived from the synchronized bus pins
    typedef struct packed {
        logic shift;    // rising serial clock with strobe low: sample input
        logic drive;    // falling serial clock with strobe low: update output
        logic load;     // rising strobe: capture status, park command
        logic commit;   // falling strobe: make parked command live
    } sport_evt_t;

    localparam int unsigned SPORT_PIN_COUNT = 3;  // sclk, ld, din
    localparam int unsigned SPORT_PIN_SCLK  = 2;
    localparam int unsigned SPORT_PIN_LD    = 1;
    localparam int unsigned SPORT_PIN_DIN   = 0;

endpackage

// File: rtl/sport_sync.sv
// Module: multi-bit synchronizer for asynchronous bus pins.
// Every bit passes through the same number of stages, so the relative
// timing between pins is kept (data stays aligned with its clock).
// Assumes: each pin is held long enough to be seen by several clk edges.
module sport_sync #(
    parameter int unsigned         WIDTH   = 3,
    parameter int unsigned         STAGES  = 2,
    parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            // Purpose: move one pin through its flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL[b]}};
                end else if (STAGES == 1) begin
                    chain_q[0] <= async_i[b];
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[b]};
                end
            end

            assign sync_o[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sport_edges.sv
// Module: edge detector for the synchronized serial clock and strobe.
// Turns the levels into one-cycle event pulses. Serial clock edges are
// masked while the strobe is high, so a strobe-high period freezes the
// shift path.
// Assumes: the inputs are already synchronous to clk.
module sport_edges
    import sport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_s,
    input  logic       ld_s,
    output sport_evt_t evt_o,
    output logic       ld_lvl_o
);

    logic sclk_prev_q;
    logic ld_prev_q;

    // Purpose: remember last cycle's levels (idle: clock high, strobe low)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b1;
            ld_prev_q   <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
            ld_prev_q   <= ld_s;
        end
    end

    // Purpose: form the event pulses
    always_comb begin
        evt_o.shift  = sclk_s & ~sclk_prev_q & ~ld_s;
        evt_o.drive  = ~sclk_s & sclk_prev_q & ~ld_s;
        evt_o.load   = ld_s & ~ld_prev_q;
        evt_o.commit = ~ld_s & ld_prev_q;
    end

    assign ld_lvl_o = ld_s;

endmodule

// File: rtl/sport_shifter.sv
// Module: serial shift register with parallel status load and a
// registered serial output.
// Samples on shift events, updates the output on drive events and loads
// the status word on load events. The output copies the top stage, so
// devices can be chained.
// Assumes: the load and shift events never coincide (shift is masked
// while the strobe is high).
module sport_shifter
    import sport_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sport_evt_t        evt_i,
    input  logic              ld_lvl_i,
    input  logic              din_s,
    input  logic [WORD_W-1:0] status_i,
    output logic [WORD_W-1:0] shreg_o,
    output logic              dout_o
);

    localparam int unsigned TOP = WORD_W - 1;

    logic [WORD_W-1:0] shreg_q;
    logic              dout_q;

    // Purpose: shift in MSB first, or take a parallel status snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (evt_i.load) begin
            shreg_q <= status_i;
        end else if (evt_i.shift) begin
            shreg_q <= {shreg_q[TOP-1:0], din_s};
        end
    end

    // Purpose: present the top stage on falling serial clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (evt_i.drive) begin
            dout_q <= shreg_q[TOP];
        end
    end

    assign shreg_o = shreg_q;
    assign dout_o  = dout_q;

    // R4: a strobe rise places the live status word in the register
    p_status_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.load |=> (shreg_q == $past(status_i)));

    // R5: the output pin moves only after a falling serial clock edge
    p_dout_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_q) |-> $past(evt_i.drive));

    // R6: strobe-high periods leave the register untouched
    p_ignore_ld_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lvl_i && !evt_i.load) |=> $stable(shreg_q));

endmodule

// File: rtl/sport_cmdreg.sv
// Module: two-stage command register.
// A strobe rise parks the shifted word as a pending command (the shift
// register is about to be overwritten by status). A strobe fall then
// makes the pending word the live command. It also drives the data-line
// pull-up control bit.
// Assumes: the rise and fall of the strobe are separate cycles.
module sport_cmdreg
    import sport_pkg::*;
#(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned PULLUP_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sport_evt_t        evt_i,
    input  logic [WORD_W-1:0] shreg_i,
    output logic [WORD_W-1:0] cmd_o,
    output logic              pullup_en_o
);

    logic [WORD_W-1:0] pend_q;
    logic [WORD_W-1:0] cmd_q;

    // Purpose: park the shifted word before status overwrites it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (evt_i.load) begin
            pend_q <= shreg_i;
        end
    end

    // Purpose: commit the parked word on the strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (evt_i.commit) begin
            cmd_q <= pend_q;
        end
    end

    assign cmd_o       = cmd_q;
    assign pullup_en_o = ~cmd_q[PULLUP_BIT];

    // R3: a strobe fall delivers the parked word
    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.commit |=> (cmd_q == $past(pend_q)));

    // R9: the command holds between commits
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i.commit |=> $stable(cmd_q));

    // R3: parked word equals the shift register seen at the strobe rise
    p_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.load |=> (pend_q == $past(shreg_i)));

endmodule

// File: rtl/cmd_status_sport.sv
// Module: chainable command/status serial port (top).
// Synchronizes the three bus pins, turns them into events, and connects
// the shift register and the command register.
// Assumes: the bus pins change slowly compared with clk (each level held
// for at least SYNC_STAGES + 2 clk cycles). status_in is synchronous to
// clk.
module cmd_status_sport #(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PULLUP_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              ld,
    input  logic              din,
    output logic              dout,
    input  logic [WORD_W-1:0] status_in,
    output logic [WORD_W-1:0] cmd_out,
    output logic              data_pullup_en
);
    import sport_pkg::*;

    localparam int unsigned PINS = SPORT_PIN_COUNT;
    // Idle levels: clock high, strobe low, data low
    localparam logic [PINS-1:0] PIN_IDLE = PINS'(1) << SPORT_PIN_SCLK;

    logic [PINS-1:0]   pins_async;
    logic [PINS-1:0]   pins_sync;
    sport_evt_t        evt;
    logic              ld_lvl;
    logic [WORD_W-1:0] shreg;

    assign pins_async[SPORT_PIN_SCLK] = sclk;
    assign pins_async[SPORT_PIN_LD]   = ld;
    assign pins_async[SPORT_PIN_DIN]  = din;

    sport_sync #(
        .WIDTH   (PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_async),
        .sync_o  (pins_sync)
    );

    sport_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_sync[SPORT_PIN_SCLK]),
        .ld_s     (pins_sync[SPORT_PIN_LD]),
        .evt_o    (evt),
        .ld_lvl_o (ld_lvl)
    );

    sport_shifter #(
        .WORD_W (WORD_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .ld_lvl_i (ld_lvl),
        .din_s    (pins_sync[SPORT_PIN_DIN]),
        .status_i (status_in),
        .shreg_o  (shreg),
        .dout_o   (dout)
    );

    sport_cmdreg #(
        .WORD_W     (WORD_W),
        .PULLUP_BIT (PULLUP_BIT)
    ) u_cmdreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .shreg_i     (shreg),
        .cmd_o       (cmd_out),
        .pullup_en_o (data_pullup_en)
    );

endmodule

// File: tb/cmd_status_sport_test.sv
// Directed bench: one task per scenario, each checking its own results.
// A second instance sits after uut on the serial chain for R7.
module cmd_status_sport_test;

    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 6;      // clk cycles per bus level
    localparam int W          = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b1;
    logic         ld = 1'b0;
    logic         din = 1'b0;
    logic         dout_a, dout_b;
    logic [W-1:0] stat_a = '0, stat_b = '0;
    logic [W-1:0] cmd_a, cmd_b;
    logic         pu_a, pu_b;

    int n_checks = 0;
    int n_bad    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_status_sport uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ld(ld), .din(din),
        .dout(dout_a), .status_in(stat_a), .cmd_out(cmd_a),
        .data_pullup_en(pu_a)
    );

    cmd_status_sport uut_far (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ld(ld), .din(dout_a),
        .dout(dout_b), .status_in(stat_b), .cmd_out(cmd_b),
        .data_pullup_en(pu_b)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_phase();
        repeat (PHASE) @(negedge clk);
    endtask

    // Shift n bits MSB first; the read word comes from the chosen dout
    task automatic shift_bits(input logic [31:0] wr, input int n,
                              input bit far, output logic [31:0] rd);
        rd = '0;
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0;
            din  = wr[i];
            wait_phase();
            rd[i] = far ? dout_b : dout_a;
            sclk = 1'b1;
            wait_phase();
        end
    endtask

    task automatic pulse_ld();
        ld = 1'b1;
        wait_phase();
        ld = 1'b0;
        wait_phase();
    endtask

    // R1: reset values
    task automatic t_reset();
        check("R1 cmd", cmd_a, 32'h0);
        check("R1 dout", dout_a, 32'h0);
        check("R1 pullup", pu_a, 32'h1);
    endtask

    // R2, R3, R9: shift in a word; cmd holds until the strobe falls
    task automatic t_write(input logic [15:0] w, input logic [15:0] old);
        logic [31:0] rd;
        shift_bits({16'h0, w}, W, 1'b0, rd);
        check("R9 hold during shift", cmd_a, {16'h0, old});
        ld = 1'b1;
        wait_phase();
        check("R3 no change on rise", cmd_a, {16'h0, old});
        ld = 1'b0;
        wait_phase();
        check("R2/R3 commit", cmd_a, {16'h0, w});
    endtask

    // R4, R5: capture status at the strobe rise and read it back MSB first
    task automatic t_status(input logic [15:0] s, input logic [15:0] w);
        logic [31:0] rd;
        shift_bits({16'h0, w}, W, 1'b0, rd);
        stat_a = s;
        pulse_ld();
        stat_a = ~s;                       // later change must not matter
        check("R3 cmd after pulse", cmd_a, {16'h0, w});
        shift_bits({16'h0, w}, W, 1'b0, rd);
        check("R4/R5 status readback", rd, {16'h0, s});
        pulse_ld();
    endtask

    // R6: clock edges while the strobe is high are ignored
    task automatic t_ld_high(input logic [15:0] s);
        logic [31:0] rd;
        logic        d0;
        stat_a = s;
        ld = 1'b1;
        wait_phase();
        d0 = dout_a;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b0; din = 1'b1; wait_phase();
            sclk = 1'b1; din = 1'b0; wait_phase();
        end
        check("R6 dout frozen", dout_a, {31'h0, d0});
        ld = 1'b0;
        wait_phase();
        shift_bits({16'h0, cmd_a}, W, 1'b0, rd);
        check("R6 register intact", rd, {16'h0, s});
        pulse_ld();
    endtask

    // R8: pull-up follows command bit 3
    task automatic t_pullup();
        t_write(16'h0008, cmd_a);
        check("R8 bit3 set", pu_a, 32'h0);
        t_write(16'hFFF7, cmd_a);
        check("R8 bit3 clear", pu_a, 32'h1);
    endtask

    // R7: two chained devices
    task automatic t_chain(input logic [31:0] w, input logic [15:0] sa,
                           input logic [15:0] sb);
        logic [31:0] rd;
        shift_bits(w, 32, 1'b1, rd);
        stat_a = sa;
        stat_b = sb;
        pulse_ld();
        check("R7 far cmd", cmd_b, {16'h0, w[31:16]});
        check("R7 near cmd", cmd_a, {16'h0, w[15:0]});
        shift_bits(w, 32, 1'b1, rd);
        check("R7 chained status", rd, {sb, sa});
        pulse_ld();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wait_phase();
        t_reset();
        t_write(16'hA5C3, 16'h0000);
        t_write(16'h0001, 16'hA5C3);
        t_write(16'h8000, 16'h0001);
        t_status(16'h9E37, 16'h1234);
        t_status(16'h0001, 16'hFFFF);
        t_ld_high(16'hC0DE);
        t_pullup();
        t_chain(32'hDEAD_BEEF, 16'h1357, 16'hACE1);
        t_chain(32'h0F0F_F0F0, 16'h8001, 16'h7FFE);
        rst_n = 1'b0;
        wait_phase();
        check("R1 cmd after reset", cmd_a, 32'h0);
        check("R1 pullup after reset", pu_a, 32'h1);
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule